// File: doc/BRIEF.md
# Compressed Audio Input Buffer

This block collects a compressed audio byte stream and holds it in a byte FIFO until a downstream decoder drains it. Bytes can come in over one of two paths. On the host path, the host writes a byte to the data register of a small 2-bit register space. On the serial path, a frameless burst stream carries the bytes: there is a bit clock and a data line, and no word or frame clock, so the stream is cut into bytes purely by counting bits. A control bit chooses which path feeds the FIFO. Writes from the other path are dropped.

Flow control compares the FIFO fill against a programmable threshold. While the fill is below the threshold, the request output is low and the host may send another block. Once the fill reaches the threshold, the output goes high and the host must hold off. The same indication is mirrored into a status bit of the control register, so the host can either watch the pin or poll the register. A write that arrives while the FIFO is completely full is lost, and it raises a sticky overflow bit.

Top module: `cmp_audio_inbuf`

## Requirements
- R1: In host mode, a host write to address 2'b11 pushes `host_wdata` into the FIFO. Writes to any other address push nothing.
- R2: `req_out` is high exactly when the FIFO fill is greater than or equal to the threshold value, and low otherwise.
- R3: Reading address 2'b00 returns the control register. Bit 2 is a copy of `req_out`, bit 1 is the overflow flag, bit 0 is the source select, and bits 7:3 read 0.
- R4: A push attempted while the FIFO holds 64 bytes is discarded and sets the overflow flag. The flag stays set until a host write to address 2'b00 has bit 1 = 1. If a new overflow and a clear happen in the same cycle, the overflow wins.
- R5: In serial mode, `ser_data` is sampled on each rising edge of `ser_clk`, most significant bit first. Every 8 sampled bits form one byte that enters the FIFO. The bit counter wraps freely, so a pause in the clock in the middle of a byte does not realign it.
- R6: Control bit 0 selects the source: 0 = host writes, 1 = serial stream. Bytes from the unselected source leave the FIFO unchanged.
- R7: `rd_valid` is high when the FIFO is not empty, and `rd_data` shows the oldest byte. When `rd_en` is high and `rd_valid` is high, that byte is removed at the clock edge. `rd_en` on an empty FIFO has no effect. Bytes leave in arrival order.
- R8: After reset, the FIFO is empty, the threshold is 48, the source is host, the overflow flag is clear and `req_out` is low.
- R9: Address 2'b01 holds the 7-bit threshold in bits 6:0. It is written by a host write and reads back with bit 7 = 0. Address 2'b10 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset, also sampled by `ser_clk` |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 2 | Host register address, also selects the read data |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Register read data for `host_addr` |
| ser_clk | input | 1 | Serial burst bit clock |
| ser_data | input | 1 | Serial burst data, sampled on rising `ser_clk` |
| req_out | output | 1 | High when fill has reached the threshold (host must pause) |
| rd_en | input | 1 | Decoder pop request |
| rd_data | output | 8 | Oldest FIFO byte |
| rd_valid | output | 1 | FIFO not empty |

## Verification
The assertions assume three things about the inputs. `ser_clk` runs slowly enough that a finished serial byte stays unchanged for longer than the synchronizer needs to see its toggle. The source select changes only while the serial clock is idle. Reset is held across several `ser_clk` edges, so that the serial-side flops are cleared. The stimulus keeps to these conditions: the serial clock period is ten system clock periods, three serial edges are issued during reset, and mode writes happen only between bursts.

// File: rtl/cai_pkg.sv
// Shared definitions for the compressed audio input buffer.
// Assumes a 2-bit host address space and 8-bit register data.
package cai_pkg;

    // Host register addresses; the data address is fixed at 2'b11.
    typedef enum logic [1:0] {
        REG_CTRL   = 2'b00,
        REG_THRESH = 2'b01,
        REG_SPARE  = 2'b10,
        REG_DATA   = 2'b11
    } reg_addr_e;

    // Ingress source selection.
    typedef enum logic {
        SRC_HOST   = 1'b0,
        SRC_SERIAL = 1'b1
    } src_sel_e;

    // Bit positions inside the control register.
    localparam int CTRL_MODE_BIT  = 0;
    localparam int CTRL_OVF_BIT   = 1;
    localparam int CTRL_LEVEL_BIT = 2;

endpackage

// File: rtl/cai_ser_deser.sv
// Serial burst deserializer running on the serial bit clock.
// Samples ser_data on rising ser_clk, MSB first, and forms a byte every
// DATA_W bits using a free-running counter (no framing input exists).
// On each completed byte it updates byte_hold and flips byte_tog.
// Assumes rst_n is held low across at least one ser_clk rising edge.
module cai_ser_deser #(
    parameter int DATA_W = 8
) (
    input  logic              ser_clk,
    input  logic              rst_n,
    input  logic              ser_data,
    output logic [DATA_W-1:0] byte_hold,
    output logic              byte_tog
);
    localparam int BC_W = $clog2(DATA_W);
    localparam logic [BC_W-1:0] LAST_BIT = BC_W'(DATA_W - 1);

    logic [DATA_W-1:0] shift_q;
    logic [DATA_W-1:0] shift_nxt;
    logic [BC_W-1:0]   bit_cnt;

    // Next shift value with the new bit appended at the LSB.
    assign shift_nxt = {shift_q[DATA_W-2:0], ser_data};

    // Shift, count bits, and publish a byte every DATA_W bits.
    always_ff @(posedge ser_clk) begin
        if (!rst_n) begin
            shift_q   <= '0;
            bit_cnt   <= '0;
            byte_hold <= '0;
            byte_tog  <= 1'b0;
        end else begin
            shift_q <= shift_nxt;
            if (bit_cnt == LAST_BIT) begin
                bit_cnt   <= '0;
                byte_hold <= shift_nxt;
                byte_tog  <= ~byte_tog;
            end else begin
                bit_cnt <= bit_cnt + BC_W'(1);
            end
        end
    end

endmodule

// File: rtl/cai_tog_sync.sv
// Toggle-handshake receiver: synchronizes a level toggle from another
// clock domain and emits a single-cycle pulse per toggle.
// Assumes the toggle changes no more often than once per STAGES+2 cycles.
module cai_tog_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_in,
    output logic pulse
);
    logic [STAGES:0] sync_q;

    // Shift the foreign toggle through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[STAGES-1:0], tog_in};
        end
    end

    // A difference between the last two stages marks one toggle.
    assign pulse = sync_q[STAGES] ^ sync_q[STAGES-1];

endmodule

// File: rtl/cai_fifo.sv
// Byte FIFO with fill counter and first-word fall-through read.
// Pushes while full and pops while empty are ignored here; the caller
// decides what a dropped push means. DEPTH need not be a power of two.
module cai_fifo #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  fill,
    output logic              full,
    output logic              empty
);
    localparam logic [AW-1:0]    PTR_LAST = AW'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FILL_MAX = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic              do_push;
    logic              do_pop;

    assign full    = (fill == FILL_MAX);
    assign empty   = (fill == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rd_data = mem[rd_ptr];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Pointer advance with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + AW'(1);
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + AW'(1);
            end
        end
    end

    // Fill count tracks accepted pushes minus accepted pops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill <= '0;
        end else begin
            case ({do_push, do_pop})
                2'b10:   fill <= fill + CNT_W'(1);
                2'b01:   fill <= fill - CNT_W'(1);
                default: fill <= fill;
            endcase
        end
    end

endmodule

// File: rtl/cai_host_regs.sv
// Host register file: control (source select, sticky overflow, level
// flag), threshold, and read-data mux. Computes the level flag as
// fill >= threshold. Assumes DATA_W >= CNT_W.
module cai_host_regs
    import cai_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CNT_W      = 7,
    parameter int THRESH_RST = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              push_req,
    input  logic              fifo_full,
    input  logic [CNT_W-1:0]  fill,
    output logic [DATA_W-1:0] host_rdata,
    output src_sel_e          mode,
    output logic [CNT_W-1:0]  thresh,
    output logic              ovf,
    output logic              level_flag
);
    logic wr_ctrl;
    logic wr_thresh;
    logic unused_wdata_hi;

    assign wr_ctrl         = host_wr && (host_addr == REG_CTRL);
    assign wr_thresh       = host_wr && (host_addr == REG_THRESH);
    assign unused_wdata_hi = ^host_wdata[DATA_W-1:CNT_W];

    // Source select register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= SRC_HOST;
        end else if (wr_ctrl) begin
            mode <= src_sel_e'(host_wdata[CTRL_MODE_BIT]);
        end
    end

    // Threshold register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thresh <= CNT_W'(THRESH_RST);
        end else if (wr_thresh) begin
            thresh <= host_wdata[CNT_W-1:0];
        end
    end

    // Sticky overflow: a dropped push sets it, a write-one clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else if (push_req && fifo_full) begin
            ovf <= 1'b1;
        end else if (wr_ctrl && host_wdata[CTRL_OVF_BIT]) begin
            ovf <= 1'b0;
        end
    end

    // Flow-control level indication.
    assign level_flag = (fill >= thresh);

    // Read-data selection by address.
    always_comb begin
        host_rdata = '0;
        case (host_addr)
            REG_CTRL: begin
                host_rdata[CTRL_MODE_BIT]  = mode;
                host_rdata[CTRL_OVF_BIT]   = ovf;
                host_rdata[CTRL_LEVEL_BIT] = level_flag;
            end
            REG_THRESH: host_rdata[CNT_W-1:0] = thresh;
            default:    host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cmp_audio_inbuf.sv
// Compressed audio input buffer top. Bytes enter from host writes to the
// data address or from the frameless serial stream, chosen by the source
// select bit; they are queued in a FIFO drained by the decoder port.
// req_out rises once the fill reaches the threshold.
// Assumes ser_clk is much slower than clk (a byte spans 8 ser_clk periods).
module cmp_audio_inbuf
    import cai_pkg::*;
#(
    parameter int DEPTH       = 64,
    parameter int DATA_W      = 8,
    parameter int THRESH_RST  = 48,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              ser_clk,
    input  logic              ser_data,
    output logic              req_out,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] ser_hold;
    logic              ser_tog;
    logic              ser_pulse;
    logic              push_req;
    logic [DATA_W-1:0] push_data;
    logic [CNT_W-1:0]  fill;
    logic [CNT_W-1:0]  thresh;
    logic              fifo_full;
    logic              fifo_empty;
    logic              ovf;
    logic              level_flag;
    src_sel_e          mode;

    // Serial-side byte assembly.
    cai_ser_deser #(.DATA_W(DATA_W)) u_deser (
        .ser_clk   (ser_clk),
        .rst_n     (rst_n),
        .ser_data  (ser_data),
        .byte_hold (ser_hold),
        .byte_tog  (ser_tog)
    );

    // Crossing of the byte-ready toggle into clk.
    cai_tog_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .tog_in (ser_tog),
        .pulse  (ser_pulse)
    );

    // Ingress selection: only the chosen source can request a push.
    always_comb begin
        if (mode == SRC_SERIAL) begin
            push_req  = ser_pulse;
            push_data = ser_hold;
        end else begin
            push_req  = host_wr && (host_addr == REG_DATA);
            push_data = host_wdata;
        end
    end

    cai_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_req),
        .push_data (push_data),
        .pop       (rd_en),
        .rd_data   (rd_data),
        .fill      (fill),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    cai_host_regs #(
        .DATA_W     (DATA_W),
        .CNT_W      (CNT_W),
        .THRESH_RST (THRESH_RST)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .push_req   (push_req),
        .fifo_full  (fifo_full),
        .fill       (fill),
        .host_rdata (host_rdata),
        .mode       (mode),
        .thresh     (thresh),
        .ovf        (ovf),
        .level_flag (level_flag)
    );

    assign req_out  = level_flag;
    assign rd_valid = !fifo_empty;

endmodule

// File: rtl/cai_checker.sv
// Property checker for cmp_audio_inbuf, attached by bind below.
// Observes ports plus the fill count, threshold, overflow and push request.
module cai_checker
    import cai_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_wr,
    input logic [1:0]       host_addr,
    input logic             clr_bit,
    input logic             status_bit,
    input logic             req,
    input logic             rd_en,
    input logic             rd_valid,
    input logic             push_req,
    input logic             mode,
    input logic             ovf,
    input logic [CNT_W-1:0] fill,
    input logic [CNT_W-1:0] thresh
);
    localparam logic [CNT_W-1:0] FILL_MAX = CNT_W'(DEPTH);

    logic [CNT_W:0] fill_p1;
    assign fill_p1 = {1'b0, fill} + {{CNT_W{1'b0}}, 1'b1};

    // R4: fill never exceeds the depth.
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FILL_MAX);

    // R4: a push into a full FIFO is dropped and flags overflow.
    p_drop_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == FILL_MAX && push_req && !rd_en) |=> (fill == FILL_MAX && ovf));

    // R4: overflow holds until a write-one clear.
    p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(host_wr && host_addr == REG_CTRL && clr_bit)) |=> ovf);

    // R4: a clear without a competing overflow empties the flag.
    p_ovf_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == REG_CTRL && clr_bit && !push_req) |=> !ovf);

    // R3: the status bit read at the control address follows the pin.
    p_status_mirror_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == REG_CTRL) |-> (status_bit == req));

    // R2: a push that reaches the threshold raises the request pin.
    p_req_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && fill != FILL_MAX && !rd_en
         && !(host_wr && host_addr == REG_THRESH)
         && fill_p1 == {1'b0, thresh}) |=> req);

    // R7: a pop with no push lowers the fill by one.
    p_pop_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_valid && !push_req) |=> (fill == $past(fill) - CNT_W'(1)));

    // R6: in serial mode a host data write alone leaves the fill unchanged.
    p_host_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && host_wr && host_addr == REG_DATA && !push_req && !rd_en)
        |=> (fill == $past(fill)));

endmodule

bind cmp_audio_inbuf cai_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .clr_bit    (host_wdata[cai_pkg::CTRL_OVF_BIT]),
    .status_bit (host_rdata[cai_pkg::CTRL_LEVEL_BIT]),
    .req        (req_out),
    .rd_en      (rd_en),
    .rd_valid   (rd_valid),
    .push_req   (push_req),
    .mode       (mode),
    .ovf        (ovf),
    .fill       (fill),
    .thresh     (thresh)
);

// File: tb/cmp_audio_inbuf_tb.sv
// Bench for cmp_audio_inbuf: a behavioural queue model compared every
// clock in host-driven phases, plus directed serial-burst checks.
module cmp_audio_inbuf_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [1:0] host_addr = 2'b00;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       ser_clk = 1'b0;
    logic       ser_data = 1'b0;
    logic       req_out;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid;

    int errors = 0;
    int checks = 0;
    bit cmp_en = 1'b0;

    // Reference model state.
    int unsigned mq[$];
    int  m_thr  = 48;
    bit  m_mode = 1'b0;
    bit  m_ovf  = 1'b0;

    always #2 clk = ~clk;

    cmp_audio_inbuf u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .ser_clk    (ser_clk),
        .ser_data   (ser_data),
        .req_out    (req_out),
        .rd_en      (rd_en),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Model update at each edge; serial bytes are not modelled.
    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_thr  = 48;
            m_mode = 1'b0;
            m_ovf  = 1'b0;
        end else begin
            bit was_full;
            bit try_push;
            bit clr;
            was_full = (mq.size() == 64);
            try_push = host_wr && host_addr == 2'b11 && !m_mode;
            clr      = host_wr && host_addr == 2'b00 && host_wdata[1];
            if (rd_en && mq.size() > 0) void'(mq.pop_front());
            if (try_push && !was_full) mq.push_back(int'(host_wdata));
            if (try_push && was_full) m_ovf = 1'b1;
            else if (clr) m_ovf = 1'b0;
            if (host_wr && host_addr == 2'b00) m_mode = host_wdata[0];
            if (host_wr && host_addr == 2'b01) m_thr = int'(host_wdata[6:0]);
        end
    end

    // Per-cycle comparison of all outputs against the model.
    always @(negedge clk) begin
        if (cmp_en) begin
            int exp_rd;
            bit exp_req;
            #1;
            exp_req = (mq.size() >= m_thr);
            chk("R7 rd_valid", int'(rd_valid), int'(mq.size() > 0));
            if (mq.size() > 0) chk("R7 rd_data order", int'(rd_data), int'(mq[0]));
            chk("R2 req_out level", int'(req_out), int'(exp_req));
            case (host_addr)
                2'b00:   exp_rd = int'(exp_req) * 4 + int'(m_ovf) * 2 + int'(m_mode);
                2'b01:   exp_rd = m_thr;
                default: exp_rd = 0;
            endcase
            chk("R3/R9 host_rdata", int'(host_rdata), exp_rd);
        end
    end

    task automatic hwr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr    = 1'b1;
        host_addr  = a;
        host_wdata = d;
        @(negedge clk);
        host_wr    = 1'b0;
        host_addr  = 2'b00;
    endtask

    task automatic hrd(input logic [1:0] a, output int v);
        @(negedge clk);
        host_addr = a;
        #1;
        v = int'(host_rdata);
    endtask

    task automatic pop_chk(input int exp, input string tag);
        @(negedge clk);
        #1;
        chk(tag, int'(rd_valid), 1);
        chk(tag, int'(rd_data), exp);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ser_bit(input logic v);
        ser_data = v;
        #20 ser_clk = 1'b1;
        #20 ser_clk = 1'b0;
    endtask

    task automatic ser_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) ser_bit(b[i]);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int v;
        // Reset with serial edges so the serial side clears too.
        rst_n = 1'b0;
        repeat (3) ser_bit(1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;

        // R8: reset state.
        hrd(2'b00, v); chk("R8 ctrl after reset", v, 0);
        hrd(2'b01, v); chk("R8 threshold after reset", v, 48);
        chk("R8 rd_valid after reset", int'(rd_valid), 0);
        chk("R8 req_out after reset", int'(req_out), 0);
        hrd(2'b10, v); chk("R9 spare address reads 0", v, 0);

        // R1: data writes push; other addresses do not.
        for (int i = 0; i < 10; i++) hwr(2'b11, 8'(8'hA0 + i));
        hwr(2'b10, 8'hFF);
        @(negedge clk); #1;
        chk("R1 first byte at head", int'(rd_data), 8'hA0);

        // R9 / R2 / R3: threshold crossing.
        hwr(2'b01, 8'd12);
        hrd(2'b01, v); chk("R9 threshold readback", v, 12);
        hwr(2'b11, 8'h5A);
        @(negedge clk); #1;
        chk("R2 req low at 11 of 12", int'(req_out), 0);
        hwr(2'b11, 8'h5B);
        @(negedge clk); #1;
        chk("R2 req high at 12 of 12", int'(req_out), 1);
        hrd(2'b00, v); chk("R3 status bit set", v, 4);

        // R7: drain in order, then pop on empty.
        for (int i = 0; i < 10; i++) pop_chk(8'hA0 + i, "R7 drain order");
        pop_chk(8'h5A, "R7 drain order");
        pop_chk(8'h5B, "R7 drain order");
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        #1;
        chk("R7 pop on empty keeps empty", int'(rd_valid), 0);

        // R4: overfill, sticky flag, write-one clear.
        hwr(2'b01, 8'd64);
        for (int i = 0; i < 66; i++) hwr(2'b11, 8'(i));
        hrd(2'b00, v); chk("R4 overflow and level set", v, 6);
        hwr(2'b00, 8'h00);
        hrd(2'b00, v); chk("R4 overflow sticky without clear", v, 6);
        hwr(2'b00, 8'h02);
        hrd(2'b00, v); chk("R4 overflow cleared", v, 4);
        for (int i = 0; i < 64; i++) pop_chk(i, "R4 dropped bytes absent");
        @(negedge clk); #1;
        chk("R4 empty after 64 pops", int'(rd_valid), 0);

        // R6: serial mode ignores host data writes.
        hwr(2'b00, 8'h01);
        hwr(2'b11, 8'h55);
        @(negedge clk); #1;
        chk("R6 host write ignored in serial mode", int'(rd_valid), 0);
        hwr(2'b01, 8'd3);

        // R5: serial bursts, MSB first, one byte split by a pause.
        cmp_en = 1'b0;
        ser_byte(8'h3C);
        ser_byte(8'hA5);
        for (int i = 7; i >= 4; i--) ser_bit(v_bit(8'h81, i));
        repeat (30) @(negedge clk);
        for (int i = 3; i >= 0; i--) ser_bit(v_bit(8'h81, i));
        ser_byte(8'h7E);
        repeat (30) @(negedge clk);
        #1;
        chk("R2 req high after 4 serial bytes", int'(req_out), 1);
        pop_chk(8'h3C, "R5 serial byte 0");
        pop_chk(8'hA5, "R5 serial byte 1");
        pop_chk(8'h81, "R5 split serial byte");
        pop_chk(8'h7E, "R5 serial byte 3");
        @(negedge clk); #1;
        chk("R5 serial drained", int'(rd_valid), 0);
        cmp_en = 1'b1;

        // R6: host mode ignores the serial stream.
        hwr(2'b00, 8'h00);
        ser_byte(8'h11);
        ser_byte(8'h22);
        repeat (30) @(negedge clk);
        #1;
        chk("R6 serial ignored in host mode", int'(rd_valid), 0);
        hwr(2'b11, 8'h99);
        @(negedge clk); #1;
        chk("R1 host write after serial", int'(rd_data), 8'h99);

        repeat (4) @(negedge clk);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    function automatic logic v_bit(input logic [7:0] b, input int i);
        return b[i];
    endfunction

endmodule